// File: doc/BRIEF.md
# Timestamp Counter with Coherent Split Read

A wide free-running up-counter that serves as a system time base. It advances by one on every clock cycle in which the tick-enable input is high and the software run flag is set. An external divider supplies that tick at the time-base rate, and producing it is outside this block. The counter raises no interrupt and has no reload or compare logic.

Software reads the counter over a 32-bit register port that exposes two word registers. A read of the low word returns the bottom bits of the count. In the same cycle that read freezes the top bits of the count into a shadow byte. A later read of the high word returns that frozen byte, so a low read followed by a high read always forms one coherent wide value, even if the low part carries into the top bits between the two accesses. The high word also holds the run flag, at bit 8, which software sets to start counting and clears to stop it.

Top module: `stamp_timer`

## Requirements
- R1: After a synchronous reset the count, the shadow byte and the run flag are all zero, and `rd_valid` is low.
- R2: The count advances by exactly one on each clock edge where `tick_en` is high and the run flag is set. In every other cycle it holds its value.
- R3: A read of the low word (address `LO_ADDR`, default 0x00) returns count bits `LO_W-1:0` on `rd_data` one cycle later, with all higher data bits zero.
- R4: A low-word read also copies count bits `LO_W+HI_W-1:LO_W` into the shadow. A read of the high word (address `HI_ADDR`, default 0x04) returns the shadow in bits `HI_W-1:0` and the run flag in bit 8, with every other bit zero. The shadow changes only on a low-word read.
- R5: When a tick and a low-word read fall in the same cycle, both the returned low word and the captured shadow come from the value the count had before that tick.
- R6: A write to the high word sets the run flag from write-data bit 8 and ignores every other data bit. It changes neither the count nor the shadow.
- R7: A write to the low word or to any unmapped address has no effect, and a read of an unmapped address returns zero.
- R8: The count wraps from all ones to zero and keeps counting.
- R9: `rd_valid` is high in exactly the cycle after each read access, and `rd_data` is zero whenever `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Count tick, one cycle wide per time-base period |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| rd_data | output | DATA_W (32) | Registered read data |
| rd_valid | output | 1 | Read data valid, one cycle after the read |

## Verification
The reference model runs alongside two instances: the full-width default and a narrow build (6-bit low word, 2-bit shadow) in which carries into the shadow and the full wrap happen within a few hundred ticks. The stimulus runs the ticks in several shapes: held off, continuous, alternating, and landing in the same cycle as a low read. These shapes separate an enable that gates the ticks from one that does not, and a pre-increment capture from a post-increment one. High reads placed after further ticks show whether the shadow is frozen or tracks the live count. Writes carrying stray data bits, writes to the low word and accesses to unmapped addresses show whether anything outside bit 8 of the high word leaks into the state.

// File: rtl/stamp_timer_pkg.sv
package stamp_timer_pkg;

  // Decoded register access for one bus cycle
  typedef enum logic [2:0] {
    ACC_NONE   = 3'd0,
    ACC_LO_RD  = 3'd1,
    ACC_HI_RD  = 3'd2,
    ACC_HI_WR  = 3'd3,
    ACC_UNK_RD = 3'd4
  } acc_e;

  function automatic logic is_read(input acc_e a);
    return (a == ACC_LO_RD) || (a == ACC_HI_RD) || (a == ACC_UNK_RD);
  endfunction

endpackage

// File: rtl/stamp_timer_decode.sv
module stamp_timer_decode
  import stamp_timer_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int LO_ADDR = 0,
  parameter int HI_ADDR = 4
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output acc_e              acc
);

  localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(LO_ADDR);
  localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(HI_ADDR);

  always_comb begin
    acc = ACC_NONE;
    if (sel) begin
      if (!wr) begin
        if (addr == LO_A)      acc = ACC_LO_RD;
        else if (addr == HI_A) acc = ACC_HI_RD;
        else                   acc = ACC_UNK_RD;
      end else if (addr == HI_A) begin
        acc = ACC_HI_WR;
      end
    end
  end

endmodule

// File: rtl/stamp_timer_count.sv
module stamp_timer_count #(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             run,
  output logic [CNT_W-1:0] cnt
);

  logic step;
  assign step = tick & run;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (step) cnt <= cnt + CNT_W'(1);
  end

  // R2: no tick or no run flag means the count is frozen
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !(tick && run) |=> $stable(cnt));

  // R2, R8: one step per qualified tick, wrapping modulo 2**CNT_W
  a_r8_step_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && run) |=> (cnt == CNT_W'($past(cnt) + CNT_W'(1))));

endmodule

// File: rtl/stamp_timer_regs.sv
module stamp_timer_regs
  import stamp_timer_pkg::*;
#(
  parameter int LO_W   = 32,
  parameter int HI_W   = 8,
  parameter int DATA_W = 32,
  parameter int EN_BIT = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  acc_e                   acc,
  input  logic [LO_W+HI_W-1:0]   cnt,
  input  logic [DATA_W-1:0]      wdata,
  output logic                   run,
  output logic [DATA_W-1:0]      rd_data,
  output logic                   rd_valid
);

  localparam int CNT_W = LO_W + HI_W;

  logic [HI_W-1:0]   shadow;
  logic [DATA_W-1:0] lo_word;
  logic [DATA_W-1:0] hi_word;
  logic [DATA_W-1:0] rd_next;

  // Low word: bottom field of the live count, zero-extended
  assign lo_word = DATA_W'(cnt[LO_W-1:0]);

  // High word: frozen top field plus the run flag
  always_comb begin
    hi_word             = '0;
    hi_word[HI_W-1:0]   = shadow;
    hi_word[EN_BIT]     = run;
  end

  always_comb begin
    case (acc)
      ACC_LO_RD: rd_next = lo_word;
      ACC_HI_RD: rd_next = hi_word;
      default:   rd_next = '0;
    endcase
  end

  // Shadow and run flag
  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      run    <= 1'b0;
    end else begin
      if (acc == ACC_LO_RD) shadow <= cnt[CNT_W-1:LO_W];
      if (acc == ACC_HI_WR) run    <= wdata[EN_BIT];
    end
  end

  // Registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_data  <= rd_next;
      rd_valid <= is_read(acc);
    end
  end

  // R4: a low read freezes the top field of the count seen in that cycle
  a_r4_capture: assert property (@(posedge clk) disable iff (rst)
    (acc == ACC_LO_RD) |=> (shadow == $past(cnt[CNT_W-1:LO_W])));

  // R4, R6: the shadow moves only on a low read
  a_r6_shadow_kept: assert property (@(posedge clk) disable iff (rst)
    (acc != ACC_LO_RD) |=> $stable(shadow));

  // R6: the run flag moves only on a high write
  a_r6_run_kept: assert property (@(posedge clk) disable iff (rst)
    (acc != ACC_HI_WR) |=> $stable(run));

  // R9: data is zero whenever no read result is presented
  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_data == '0));

  // R3: bits above the low field never appear on a low read
  a_r3_lo_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (acc == ACC_LO_RD) |=> ((rd_data >> LO_W) == '0));

endmodule

// File: rtl/stamp_timer.sv
module stamp_timer
  import stamp_timer_pkg::*;
#(
  parameter int LO_W    = 32,
  parameter int HI_W    = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int LO_ADDR = 0,
  parameter int HI_ADDR = 4,
  parameter int EN_BIT  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  localparam int CNT_W = LO_W + HI_W;

  acc_e             acc;
  logic             run;
  logic [CNT_W-1:0] cnt;

  stamp_timer_decode #(
    .ADDR_W  (ADDR_W),
    .LO_ADDR (LO_ADDR),
    .HI_ADDR (HI_ADDR)
  ) u_decode (
    .sel  (bus_sel),
    .wr   (bus_wr),
    .addr (bus_addr),
    .acc  (acc)
  );

  stamp_timer_count #(
    .CNT_W (CNT_W)
  ) u_count (
    .clk  (clk),
    .rst  (rst),
    .tick (tick_en),
    .run  (run),
    .cnt  (cnt)
  );

  stamp_timer_regs #(
    .LO_W   (LO_W),
    .HI_W   (HI_W),
    .DATA_W (DATA_W),
    .EN_BIT (EN_BIT)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .acc      (acc),
    .cnt      (cnt),
    .wdata    (bus_wdata),
    .run      (run),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  // R9: a read result appears exactly one cycle after each read access
  a_r9_valid_timing: assert property (@(posedge clk) disable iff (rst)
    rd_valid == $past(bus_sel && !bus_wr));

  // R1: reset leaves the read port idle
  a_r1_reset_idle: assert property (@(posedge clk)
    $past(rst) |-> (!rd_valid && rd_data == '0));

endmodule

// File: tb/tb_stamp_timer.sv
module tb_stamp_timer;

  logic        clk = 1'b0;
  logic        rst;
  logic        tick_en;
  logic        bus_sel;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] rd_data,  rd_data_s;
  logic        rd_valid, rd_valid_s;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  stamp_timer dut (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  // Narrow build: wraps after 256 ticks
  stamp_timer #(.LO_W(6), .HI_W(2)) dut_s (
    .clk(clk), .rst(rst), .tick_en(tick_en), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_data(rd_data_s), .rd_valid(rd_valid_s)
  );

  // Behavioural reference: index 0 = default build, 1 = narrow build
  longint unsigned m_cnt[2], m_sh[2], m_dat[2];
  bit              m_en[2], m_vld[2];
  int              lw[2] = '{32, 6};
  int              hw[2] = '{8, 2};

  task automatic model_edge();
    for (int i = 0; i < 2; i++) begin
      longint unsigned lomask = (64'd1 << lw[i]) - 1;
      longint unsigned himask = (64'd1 << hw[i]) - 1;
      longint unsigned allmsk = (64'd1 << (lw[i] + hw[i])) - 1;
      bit lo_rd = bus_sel && !bus_wr && bus_addr == 8'h00;
      bit hi_rd = bus_sel && !bus_wr && bus_addr == 8'h04;
      bit hi_wr = bus_sel &&  bus_wr && bus_addr == 8'h04;
      longint unsigned c0 = m_cnt[i];
      bit e0 = m_en[i];
      if (rst) begin
        m_cnt[i] = 0; m_sh[i] = 0; m_en[i] = 0; m_vld[i] = 0; m_dat[i] = 0;
      end else begin
        m_vld[i] = bus_sel && !bus_wr;
        m_dat[i] = lo_rd ? (c0 & lomask) :
                   hi_rd ? ((longint'(e0) << 8) | m_sh[i]) : 0;
        if (lo_rd) m_sh[i] = (c0 >> lw[i]) & himask;
        if (hi_wr) m_en[i] = bus_wdata[8];
        if (tick_en && e0) m_cnt[i] = (c0 + 1) & allmsk;
      end
    end
  endtask

  task automatic check_one(string inst, logic [31:0] ad, logic av,
                           longint unsigned ed, bit ev);
    checks++;
    if (av !== ev || ad !== 32'(ed)) begin
      errors++;
      $display("FAIL %s %s: rd_valid=%0b rd_data=%h expected rd_valid=%0b rd_data=%h",
               phase, inst, av, ad, ev, 32'(ed));
    end
  endtask

  // One bus cycle: drive after the falling edge, compare after the next one
  task automatic step(bit r, bit t, bit s, bit w, logic [7:0] a, logic [31:0] d);
    rst = r; tick_en = t; bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_one("wide",   rd_data,   rd_valid,   m_dat[0], m_vld[0]);
    check_one("narrow", rd_data_s, rd_valid_s, m_dat[1], m_vld[1]);
  endtask

  task automatic idle(bit t);           step(0, t, 0, 0, 8'h00, 32'h0); endtask
  task automatic rd(bit t, logic [7:0] a); step(0, t, 1, 0, a, 32'h0); endtask
  task automatic wr(bit t, logic [7:0] a, logic [31:0] d); step(0, t, 1, 1, a, d); endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        errors++;
        $display("FAIL watchdog: cycles=%0d expected below 200000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst = 1; tick_en = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    @(negedge clk);
    // R1: reset state, including a read issued while reset is held
    phase = "R1";
    step(1, 1, 0, 0, 8'h00, 0);
    step(1, 1, 1, 0, 8'h00, 0);
    step(1, 0, 0, 0, 8'h00, 0);
    rd(0, 8'h00); rd(0, 8'h04); idle(0);

    // R2: ticks with the run flag clear do not count
    phase = "R2";
    for (int k = 0; k < 5; k++) idle(1);
    rd(1, 8'h00); idle(0);

    // R6: stray data bits with bit 8 clear leave everything stopped
    phase = "R6";
    wr(1, 8'h04, 32'hFFFF_FEFF);
    rd(1, 8'h04); rd(1, 8'h00); idle(0);

    // R2: run, continuous ticks then alternating ticks
    phase = "R2";
    wr(0, 8'h04, 32'h0000_0100);
    for (int k = 0; k < 10; k++) idle(1);
    rd(0, 8'h00);
    for (int k = 0; k < 12; k++) idle(k[0]);
    rd(0, 8'h00); rd(0, 8'h04);

    // R5: tick coincides with a low read, then high read
    phase = "R5";
    for (int k = 0; k < 40; k++) idle(1);
    rd(1, 8'h00); rd(1, 8'h04); rd(1, 8'h00); rd(0, 8'h04);

    // R4: high read after further ticks still shows the frozen field
    phase = "R4";
    for (int k = 0; k < 70; k++) idle(1);
    rd(1, 8'h04); rd(0, 8'h00); rd(0, 8'h04);

    // R7: low-word write and unmapped accesses change nothing
    phase = "R7";
    wr(0, 8'h00, 32'hFFFF_FFFF);
    wr(0, 8'h08, 32'hFFFF_FFFF);
    rd(0, 8'h08); rd(0, 8'h3C); rd(0, 8'h00); rd(0, 8'h04);

    // R6: high write with bit 8 set keeps the count and the shadow
    phase = "R6";
    wr(0, 8'h04, 32'hFFFF_FFFF);
    rd(0, 8'h04); rd(0, 8'h00);

    // R8: run past the narrow build's wrap with periodic reads
    phase = "R8";
    for (int k = 0; k < 300; k++) begin
      if (k % 17 == 0) rd(1, 8'h00);
      else if (k % 17 == 1) rd(1, 8'h04);
      else idle(1);
    end

    // R9: back-to-back reads, then idle cycles
    phase = "R9";
    rd(1, 8'h00); rd(1, 8'h00); rd(1, 8'h04); idle(0); idle(0);

    // R2: clearing the run flag stops the count
    phase = "R2";
    wr(1, 8'h04, 32'h0);
    for (int k = 0; k < 8; k++) idle(1);
    rd(1, 8'h00); rd(1, 8'h04); idle(0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule